// File: doc/BRIEF.md
# AHB Master Event Monitor

This block sits beside an AHB bus and only listens. It watches one master and one slave, both picked by configuration inputs, and keeps five 32-bit tallies. Four of them count occurrences: new bus tenures won by the master, NONSEQ transfers the master starts, RETRY responses given to the master, and SPLIT responses from the watched slave. The fifth counts duration: it adds one for every clock in which the master is asking for the bus and does not yet hold it. This gives the total time the master spent waiting for arbitration.

Each tally has a sticky wrap flag. A global enable freezes all tallies, and a synchronous clear resets tallies and flags together. Software reads the outputs through whatever register shell the chip places around the block. That shell is not part of this block.

Top module: `ahb_evt_monitor`

## Requirements
- R1: After reset every tally is zero and every wrap flag is low.
- R2: The grant tally adds one on a cycle with `hready` high and `hmaster` equal to `cfg_mst`, provided that `htrans` is NONSEQ (2'b10) or the previous `hready`-high cycle showed a different `hmaster`. SEQ, BUSY and waited cycles that continue the same master's tenure are not counted.
- R3: The transfer tally adds one on a cycle with `hready` high, `hmaster` equal to `cfg_mst` and `htrans` equal to NONSEQ (2'b10). A NONSEQ held through wait cycles therefore counts once.
- R4: The retry tally adds one on a cycle with `hmaster` equal to `cfg_mst`, `hresp` equal to RETRY (2'b10) and `hready` low. This is the first cycle of the two-cycle response, so each response counts once. RETRY seen while another master owns the bus is ignored.
- R5: The split tally adds one on a cycle with `hsel[cfg_slv]` high, `hresp` equal to SPLIT (2'b11) and `hready` low, whatever the value of `hmaster`. SPLIT seen while another slave is selected is ignored.
- R6: The latency tally adds one for every cycle in which `hbusreq[cfg_mst]` is high and `hgrant[cfg_mst]` is low. Requests from other masters have no effect.
- R7: Every tally is registered. A qualifying cycle is visible on the output one clock later, and a tally grows by exactly one per qualifying cycle.
- R8: While `en` is low, no tally and no wrap flag changes.
- R9: `clr` high zeroes all tallies and all wrap flags on the next clock. It takes priority over `en` and over any event in the same cycle.
- R10: A tally at all-ones that takes another event wraps to zero and sets its wrap flag. The flag stays high through later counting until `clr`. The flag bit order in `ovf` is grant 0, transfer 1, retry 2, split 3, latency 4.
- R11: Events are matched against the `cfg_mst` and `cfg_slv` present in the same cycle. A new selection therefore governs the very cycle in which it appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mst | input | MST_W (4) | Index of the watched master |
| cfg_slv | input | SLV_W (3) | Index of the watched slave |
| en | input | 1 | Counting enable |
| clr | input | 1 | Synchronous clear of tallies and flags |
| hmaster | input | MST_W (4) | Current bus owner |
| htrans | input | 2 | Transfer type |
| hresp | input | 2 | Slave response |
| hready | input | 1 | Transfer done / bus ready |
| hsel | input | NSLV (8) | Slave select lines |
| hbusreq | input | NMST (16) | Bus request per master |
| hgrant | input | NMST (16) | Bus grant per master |
| cnt_grant | output | CNT_W (32) | Grant tally |
| cnt_xfer | output | CNT_W (32) | Transfer tally |
| cnt_retry | output | CNT_W (32) | Retry tally |
| cnt_split | output | CNT_W (32) | Split tally |
| cnt_lat | output | CNT_W (32) | Request-to-grant latency tally |
| ovf | output | 5 | Sticky wrap flags |

## Verification
Each tally passes through exactly one register. The stimulus for a bus cycle is driven on a falling edge, the rising edge after it captures the event, and the output is read on the next falling edge. A clear follows the same one-clock rule. The checks therefore compare values one falling edge after each driven cycle, never mid-edge. The wrap case uses a second instance with a 4-bit tally, so that wrap-around arrives after 16 latency cycles.

// File: rtl/ahb_pmu_pkg.sv
package ahb_pmu_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } htrans_e;

    typedef enum logic [1:0] {
        RS_OKAY  = 2'b00,
        RS_ERROR = 2'b01,
        RS_RETRY = 2'b10,
        RS_SPLIT = 2'b11
    } hresp_e;

    // event slot order, also the bit order of the wrap flags
    localparam int EV_GNT = 0;
    localparam int EV_XFR = 1;
    localparam int EV_RTY = 2;
    localparam int EV_SPL = 3;
    localparam int EV_LAT = 4;
    localparam int EV_NUM = 5;

endpackage

// File: rtl/ahb_pmu_evt_detect.sv
module ahb_pmu_evt_detect
    import ahb_pmu_pkg::*;
#(
    parameter int NMST  = 16,
    parameter int NSLV  = 8,
    parameter int MST_W = $clog2(NMST),
    parameter int SLV_W = $clog2(NSLV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MST_W-1:0]  cfg_mst,
    input  logic [SLV_W-1:0]  cfg_slv,
    input  logic [MST_W-1:0]  hmaster,
    input  logic [1:0]        htrans,
    input  logic [1:0]        hresp,
    input  logic              hready,
    input  logic [NSLV-1:0]   hsel,
    input  logic [NMST-1:0]   hbusreq,
    input  logic [NMST-1:0]   hgrant,
    output logic [EV_NUM-1:0] evt
);

    // owner of the last ready-qualified address phase
    typedef struct packed {
        logic [MST_W-1:0] last_mst;
        logic             last_vld;
    } trk_t;

    trk_t trk_d, trk_q;

    logic mst_hit;
    logic fresh_owner;
    logic is_nseq;

    always_comb begin
        trk_d       = trk_q;
        evt         = '0;
        mst_hit     = (hmaster == cfg_mst);
        is_nseq     = (htrans == TR_NSEQ);
        fresh_owner = !trk_q.last_vld || (trk_q.last_mst != hmaster);

        // new tenure or new transaction of the watched master
        evt[EV_GNT] = hready && mst_hit && (is_nseq || fresh_owner);
        // transfer start, counted on the accepted cycle only
        evt[EV_XFR] = hready && mst_hit && is_nseq;
        // first cycle of a two-cycle RETRY response
        evt[EV_RTY] = !hready && mst_hit && (hresp == RS_RETRY);
        // first cycle of a two-cycle SPLIT response from the watched slave
        evt[EV_SPL] = !hready && hsel[cfg_slv] && (hresp == RS_SPLIT);
        // duration: waiting for the bus
        evt[EV_LAT] = hbusreq[cfg_mst] && !hgrant[cfg_mst];

        if (hready) begin
            trk_d.last_mst = hmaster;
            trk_d.last_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // R4: a legal two-cycle response never yields two retry events in a row
    p_retry_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt[EV_RTY] |=> !evt[EV_RTY]);

    // R5: same for split
    p_split_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt[EV_SPL] |=> !evt[EV_SPL]);

    // R2: a SEQ beat continuing the same owner's tenure is not a new grant
    p_seq_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && (htrans == TR_SEQ) && trk_q.last_vld &&
         (trk_q.last_mst == hmaster)) |-> !evt[EV_GNT]);

endmodule

// File: rtl/ahb_pmu_counter.sv
module ahb_pmu_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (clr) begin
            ctr_d.cnt = '0;
            ctr_d.ovf = 1'b0;
        end else if (inc) begin
            ctr_d.cnt = ctr_q.cnt + CNT_W'(1);
            if (&ctr_q.cnt) begin
                ctr_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt = ctr_q.cnt;
    assign ovf = ctr_q.ovf;

    // R9: clear wins
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0) && !ovf);

    // R7: one step per event
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R8: nothing moves without an event
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt) && $stable(ovf));

    // R10: wrap raises the flag
    p_wrap_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && (&cnt)) |=> ovf && (cnt == '0));

    // R10: flag is sticky
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

endmodule

// File: rtl/ahb_evt_monitor.sv
module ahb_evt_monitor
    import ahb_pmu_pkg::*;
#(
    parameter int NMST  = 16,
    parameter int NSLV  = 8,
    parameter int CNT_W = 32,
    parameter int MST_W = $clog2(NMST),
    parameter int SLV_W = $clog2(NSLV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MST_W-1:0]  cfg_mst,
    input  logic [SLV_W-1:0]  cfg_slv,
    input  logic              en,
    input  logic              clr,
    input  logic [MST_W-1:0]  hmaster,
    input  logic [1:0]        htrans,
    input  logic [1:0]        hresp,
    input  logic              hready,
    input  logic [NSLV-1:0]   hsel,
    input  logic [NMST-1:0]   hbusreq,
    input  logic [NMST-1:0]   hgrant,
    output logic [CNT_W-1:0]  cnt_grant,
    output logic [CNT_W-1:0]  cnt_xfer,
    output logic [CNT_W-1:0]  cnt_retry,
    output logic [CNT_W-1:0]  cnt_split,
    output logic [CNT_W-1:0]  cnt_lat,
    output logic [EV_NUM-1:0] ovf
);

    logic [EV_NUM-1:0]            evt;
    logic [EV_NUM-1:0]            inc;
    logic [EV_NUM-1:0][CNT_W-1:0] cnt_vec;

    ahb_pmu_evt_detect #(
        .NMST  (NMST),
        .NSLV  (NSLV),
        .MST_W (MST_W),
        .SLV_W (SLV_W)
    ) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_mst (cfg_mst),
        .cfg_slv (cfg_slv),
        .hmaster (hmaster),
        .htrans  (htrans),
        .hresp   (hresp),
        .hready  (hready),
        .hsel    (hsel),
        .hbusreq (hbusreq),
        .hgrant  (hgrant),
        .evt     (evt)
    );

    assign inc = evt & {EV_NUM{en}};

    for (genvar i = 0; i < EV_NUM; i++) begin : g_ctr
        ahb_pmu_counter #(
            .CNT_W (CNT_W)
        ) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc[i]),
            .cnt   (cnt_vec[i]),
            .ovf   (ovf[i])
        );
    end

    assign cnt_grant = cnt_vec[EV_GNT];
    assign cnt_xfer  = cnt_vec[EV_XFR];
    assign cnt_retry = cnt_vec[EV_RTY];
    assign cnt_split = cnt_vec[EV_SPL];
    assign cnt_lat   = cnt_vec[EV_LAT];

    // R8: enable low freezes the whole bank
    p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt_vec) && $stable(ovf));

    // R9: clear empties the whole bank
    p_bank_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_vec == '0) && (ovf == '0));

endmodule

// File: tb/sim_ahb_evt_monitor.sv
module sim_ahb_evt_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NMST = 16;
    localparam int NSLV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_mst = 4'd3;
    logic [2:0]  cfg_slv = 3'd2;
    logic        en = 1'b1;
    logic        clr = 1'b0;
    logic [3:0]  hmaster = 4'd0;
    logic [1:0]  htrans = 2'b00;
    logic [1:0]  hresp = 2'b00;
    logic        hready = 1'b1;
    logic [NSLV-1:0] hsel = '0;
    logic [NMST-1:0] hbusreq = '0;
    logic [NMST-1:0] hgrant = '0;

    logic [31:0] cnt_grant, cnt_xfer, cnt_retry, cnt_split, cnt_lat;
    logic [4:0]  ovf;
    logic [3:0]  n_grant, n_xfer, n_retry, n_split, n_lat;
    logic [4:0]  n_ovf;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ahb_evt_monitor u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mst(cfg_mst), .cfg_slv(cfg_slv),
        .en(en), .clr(clr), .hmaster(hmaster), .htrans(htrans),
        .hresp(hresp), .hready(hready), .hsel(hsel), .hbusreq(hbusreq),
        .hgrant(hgrant), .cnt_grant(cnt_grant), .cnt_xfer(cnt_xfer),
        .cnt_retry(cnt_retry), .cnt_split(cnt_split), .cnt_lat(cnt_lat),
        .ovf(ovf)
    );

    ahb_evt_monitor #(.CNT_W(4)) u_nw (
        .clk(clk), .rst_n(rst_n), .cfg_mst(cfg_mst), .cfg_slv(cfg_slv),
        .en(en), .clr(clr), .hmaster(hmaster), .htrans(htrans),
        .hresp(hresp), .hready(hready), .hsel(hsel), .hbusreq(hbusreq),
        .hgrant(hgrant), .cnt_grant(n_grant), .cnt_xfer(n_xfer),
        .cnt_retry(n_retry), .cnt_split(n_split), .cnt_lat(n_lat),
        .ovf(n_ovf)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic idle_bus();
        hmaster = 4'd0; htrans = 2'b00; hresp = 2'b00; hready = 1'b1;
        hsel = '0; hbusreq = '0; hgrant = '0;
    endtask

    task automatic do_clr();
        idle_bus();
        clr = 1'b1;
        cyc();
        clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 grant", cnt_grant, 0);
        chk("R1 lat", cnt_lat, 0);
        chk("R1 ovf", ovf, 0);
    endtask

    task automatic t_grant();
        do_clr();
        hmaster = 4'd3; htrans = 2'b10; hready = 1'b1; cyc();
        chk("R2 grant after NONSEQ", cnt_grant, 1);
        chk("R3 xfer after NONSEQ", cnt_xfer, 1);
        htrans = 2'b11; cyc();
        hready = 1'b0; cyc();
        hready = 1'b1; cyc();
        chk("R2 SEQ beats not counted", cnt_grant, 1);
        hmaster = 4'd5; htrans = 2'b10; cyc();
        chk("R2 other master ignored", cnt_grant, 1);
        hmaster = 4'd3; htrans = 2'b00; cyc();
        chk("R2 new tenure IDLE", cnt_grant, 2);
        htrans = 2'b10; hready = 1'b0; cyc();
        chk("R3 waited NONSEQ not yet", cnt_xfer, 1);
        hready = 1'b1; cyc();
        chk("R2 NONSEQ same owner", cnt_grant, 3);
        chk("R3 waited NONSEQ once", cnt_xfer, 2);
        idle_bus(); cyc();
    endtask

    task automatic t_retry();
        do_clr();
        hmaster = 4'd3; hresp = 2'b10; hready = 1'b0; cyc();
        hready = 1'b1; cyc();
        chk("R4 retry once per response", cnt_retry, 1);
        hmaster = 4'd4; hresp = 2'b10; hready = 1'b0; cyc();
        hready = 1'b1; cyc();
        chk("R4 other master retry ignored", cnt_retry, 1);
        idle_bus(); cyc();
    endtask

    task automatic t_split();
        do_clr();
        hmaster = 4'd7; hsel = 8'b0000_0100; hresp = 2'b11; hready = 1'b0; cyc();
        hready = 1'b1; cyc();
        chk("R5 split any master", cnt_split, 1);
        hsel = 8'b0000_0010; hready = 1'b0; cyc();
        hready = 1'b1; cyc();
        chk("R5 other slave ignored", cnt_split, 1);
        idle_bus(); cyc();
    endtask

    task automatic t_latency();
        do_clr();
        hbusreq[6] = 1'b1; cyc();
        chk("R6 other master request ignored", cnt_lat, 0);
        hbusreq[3] = 1'b1;
        for (int i = 0; i < 4; i++) cyc();
        chk("R6 wait cycles", cnt_lat, 4);
        hgrant[3] = 1'b1; cyc(); cyc();
        chk("R6 stops at grant", cnt_lat, 4);
        idle_bus(); cyc();
    endtask

    task automatic t_enable();
        do_clr();
        en = 1'b0;
        hmaster = 4'd3; htrans = 2'b10; hbusreq[3] = 1'b1; cyc();
        hresp = 2'b10; hready = 1'b0; cyc();
        chk("R8 xfer frozen", cnt_xfer, 0);
        chk("R8 lat frozen", cnt_lat, 0);
        chk("R8 retry frozen", cnt_retry, 0);
        idle_bus(); en = 1'b1;
        hmaster = 4'd3; htrans = 2'b10; cyc();
        chk("R8 counts again when enabled", cnt_xfer, 1);
        idle_bus(); cyc();
    endtask

    task automatic t_clear();
        hmaster = 4'd3; htrans = 2'b10; hbusreq[3] = 1'b1; cyc();
        chk("R7 one clock after event", cnt_xfer, 2);
        clr = 1'b1; cyc();
        clr = 1'b0;
        chk("R9 clear beats event xfer", cnt_xfer, 0);
        chk("R9 clear beats event lat", cnt_lat, 0);
        chk("R9 clear grant", cnt_grant, 0);
        idle_bus(); cyc();
    endtask

    task automatic t_select();
        do_clr();
        cfg_mst = 4'd5; hmaster = 4'd5; htrans = 2'b10; cyc();
        chk("R11 new selection same cycle", cnt_xfer, 1);
        hmaster = 4'd3; cyc();
        chk("R11 old master ignored", cnt_xfer, 1);
        cfg_mst = 4'd3; idle_bus(); cyc();
    endtask

    task automatic t_wrap();
        do_clr();
        hbusreq[3] = 1'b1;
        for (int i = 0; i < 16; i++) cyc();
        chk("R10 narrow wrap to zero", n_lat, 0);
        chk("R10 narrow flag set", n_ovf[4], 1);
        chk("R10 wide no flag", ovf, 0);
        for (int i = 0; i < 3; i++) cyc();
        chk("R10 count after wrap", n_lat, 3);
        chk("R10 flag sticky", n_ovf[4], 1);
        do_clr();
        chk("R10 flag cleared", n_ovf, 0);
        chk("R10 narrow count cleared", n_lat, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_grant();
        t_retry();
        t_split();
        t_latency();
        t_enable();
        t_clear();
        t_select();
        t_wrap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule